// File: doc/BRIEF.md
# Addressed Upstream Frame Receiver

This block takes one asynchronous serial line and turns each 16-bit upstream frame on it into a stored result. A frame is made of a start bit, a 4-bit address, 8 data bits, a parity bit and two stop bits. The two upper address bits choose one of four result slots. The slot keeps the two lower address bits, the data byte, the parity bit as it arrived, the parity the receiver computed itself, an error flag and a valid flag. The input line can be used as it is or inverted first. A 5-bit down-counter shows how far the current frame has progressed.

The clock is the oversampling clock, so each bit cell lasts `OVS` clocks. A falling edge on the line while the receiver is idle starts a frame. The receiver samples each bit at the middle of its cell and shifts it in at the end of the cell. After the second stop bit, the frame is written into its slot and a one-cycle completion pulse is raised, which can be used to request an interrupt. Software drops the valid flag of a slot through a per-slot clear input.

Top module: `upf_rx`

## Requirements
- R1: After reset the progress counter is 0, every valid flag is 0 and the completion pulse is low. While idle, the receiver starts a frame only on a high-to-low transition of the (polarity-adjusted) line. A line that stays high produces no activity.
- R2: When `sdi_invert` is 1, the line is inverted before any other use. A frame sent with inverted levels, and with an idle level of 0 on the pin, is received exactly like the same frame sent without inversion.
- R3: The progress counter is loaded with 16 when the start edge is detected. It falls by one at the end of each bit cell and is 0 once the second stop bit has been taken. It never holds a value above 16. In the middle of bit cell k (k = 0 for the start bit) it reads 16-k.
- R4: Each bit takes the line value at oversampling tick 8 of its 16-tick cell (tick 0 is the cell's first clock). Levels on other ticks of a cell do not change the received value.
- R5: Bits arrive in this order: start, address MSB first, data MSB first, parity, stop 1, stop 2. Address bits [3:2] select slot 0 to 3. That slot's low-address field (bits 2*i+1:2*i of `res_lab`) receives address bits [1:0], and its data field (bits 8*i+7:8*i of `res_data`) receives the data byte.
- R6: The parity is even over the 4 address bits and 8 data bits. `res_calcpar[i]` holds the XOR of those 12 bits and `res_rxpar[i]` holds the received parity bit. The error flag is set when the two differ.
- R7: The error flag is also set when the start bit was sampled high, or when either stop bit was sampled low.
- R8: A slot is written only when the second stop bit completes. `rx_done` is high for exactly one cycle, in the same cycle as the new slot contents and the set valid flag first appear. The progress counter reads 0 in that cycle.
- R9: Holding `clr[i]` high for a cycle clears valid flag i on the next edge. The data of that slot and every other slot are left unchanged. If a write to the same slot happens on that edge, the write wins.
- R10: A frame that targets a slot whose valid flag is still set overwrites the slot's contents, and the valid flag stays set. A set valid flag stays set until it is cleared.
- R11: Falling edges on the line during a frame do not restart reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS clocks per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial upstream data line |
| sdi_invert | input | 1 | 1 = invert the line before reception |
| clr | input | NREG (4) | Per-slot valid-flag clear |
| res_valid | output | NREG (4) | Valid flag of each slot |
| res_lab | output | NREG*LOW_W (8) | Low-address field of each slot |
| res_data | output | NREG*DATA_W (32) | Data byte of each slot |
| res_rxpar | output | NREG (4) | Received parity bit of each slot |
| res_calcpar | output | NREG (4) | Computed parity bit of each slot |
| res_perr | output | NREG (4) | Parity / framing error flag of each slot |
| prog_cnt | output | CNT_W (5) | Frame progress down-counter |
| rx_done | output | 1 | One-cycle frame-complete pulse |

## Verification
The bound checker watches, on every cycle, the counter's range, its step pattern (only single decrements or a reload from 0 to 16), the one-cycle width of the completion pulse and its alignment with a zero counter. It also checks that a valid flag rises only together with that pulse, that a clear drops the flag unless a write comes in at the same time, and that a set flag holds otherwise. Only the bench scenarios can show the values that land in the slots: address routing, bit order, the parity computation, framing errors on the start and stop bits, polarity inversion, midpoint sampling against glitchy cell edges, and the fact that edges inside a frame are ignored.

// File: rtl/upf_pkg.sv
package upf_pkg;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_BUSY = 1'b1
   } rx_state_e;

   localparam int STOP_BITS = 2;

   // start + address + data + parity + stop bits
   function automatic int frame_len(input int addr_w, input int data_w);
      return 1 + addr_w + data_w + 1 + STOP_BITS;
   endfunction

endpackage

// File: rtl/upf_line_in.sv
module upf_line_in #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic invert,
   output logic line,
   output logic fall
);

   logic                   si;
   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;

   assign si = pin ^ invert;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= si;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], si};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[SYNC_STAGES-1];
   end

   assign line = chain[SYNC_STAGES-1];
   assign fall = prev & ~line;

endmodule

// File: rtl/upf_bit_ctrl.sv
module upf_bit_ctrl
   import upf_pkg::*;
#(
   parameter int OVS        = 16,
   parameter int SAMPLE_PT  = 8,
   parameter int FRAME_BITS = 16,
   parameter int CNT_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line,
   input  logic                  fall,
   output logic [CNT_W-1:0]      prog_cnt,
   output logic                  frame_end,
   output logic [FRAME_BITS-1:0] frame
);

   localparam int TICK_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [TICK_W-1:0] TICK_SAMPLE = TICK_W'(SAMPLE_PT);
   localparam logic [TICK_W-1:0] TICK_LAST   = TICK_W'(OVS - 1);
   localparam logic [CNT_W-1:0]  CNT_LOAD    = CNT_W'(FRAME_BITS);

   rx_state_e             state;
   logic [TICK_W-1:0]     tick;
   logic [CNT_W-1:0]      cnt;
   logic                  samp;
   logic [FRAME_BITS-1:0] shreg;
   logic                  cell_end;

   assign cell_end  = (state == RX_BUSY) && (tick == TICK_LAST);
   assign frame_end = cell_end && (cnt == CNT_W'(1));
   assign frame     = {shreg[FRAME_BITS-2:0], samp};
   assign prog_cnt  = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         tick  <= '0;
         cnt   <= '0;
         samp  <= 1'b1;
         shreg <= '0;
      end else begin
         unique case (state)
            RX_IDLE: begin
               if (fall) begin
                  // the detection cycle counts as tick 0 of the start cell
                  state <= RX_BUSY;
                  tick  <= TICK_W'(1);
                  cnt   <= CNT_LOAD;
               end
            end
            RX_BUSY: begin
               if (tick == TICK_SAMPLE) samp <= line;
               if (cell_end) begin
                  tick  <= '0;
                  shreg <= frame;
                  cnt   <= cnt - CNT_W'(1);
                  if (cnt == CNT_W'(1)) state <= RX_IDLE;
               end else begin
                  tick <= tick + TICK_W'(1);
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/upf_frame_dec.sv
module upf_frame_dec
   import upf_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic [frame_len(ADDR_W, DATA_W)-1:0] frame,
   output logic [SEL_W-1:0]                     sel,
   output logic [ADDR_W-SEL_W-1:0]              lab,
   output logic [DATA_W-1:0]                    data,
   output logic                                 rxpar,
   output logic                                 calcpar,
   output logic                                 perr
);

   localparam int FB       = frame_len(ADDR_W, DATA_W);
   localparam int LOW_W    = ADDR_W - SEL_W;
   localparam int A_MSB    = FB - 2;
   localparam int D_MSB    = A_MSB - ADDR_W;
   localparam int PAR_POS  = STOP_BITS;

   logic              start_bit;
   logic [ADDR_W-1:0] addr;
   logic [STOP_BITS-1:0] stops;

   assign start_bit = frame[FB-1];
   assign addr      = frame[A_MSB -: ADDR_W];
   assign data      = frame[D_MSB -: DATA_W];
   assign rxpar     = frame[PAR_POS];
   assign stops     = frame[STOP_BITS-1:0];

   assign sel     = addr[ADDR_W-1 -: SEL_W];
   assign lab     = addr[LOW_W-1:0];
   assign calcpar = ^{addr, data};
   assign perr    = (calcpar ^ rxpar) | start_bit | ~(&stops);

endmodule

// File: rtl/upf_result_bank.sv
module upf_result_bank #(
   parameter int SEL_W  = 2,
   parameter int LOW_W  = 2,
   parameter int DATA_W = 8,
   localparam int NREG  = 1 << SEL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [SEL_W-1:0]       sel,
   input  logic [LOW_W-1:0]       lab,
   input  logic [DATA_W-1:0]      data,
   input  logic                   rxpar,
   input  logic                   calcpar,
   input  logic                   perr,
   input  logic [NREG-1:0]        clr,
   output logic [NREG-1:0]        res_valid,
   output logic [NREG*LOW_W-1:0]  res_lab,
   output logic [NREG*DATA_W-1:0] res_data,
   output logic [NREG-1:0]        res_rxpar,
   output logic [NREG-1:0]        res_calcpar,
   output logic [NREG-1:0]        res_perr
);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_slot
         logic              load;
         logic              v_q;
         logic [LOW_W-1:0]  lab_q;
         logic [DATA_W-1:0] data_q;
         logic              rp_q;
         logic              cp_q;
         logic              pe_q;

         assign load = wr && (sel == SEL_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q    <= 1'b0;
               lab_q  <= '0;
               data_q <= '0;
               rp_q   <= 1'b0;
               cp_q   <= 1'b0;
               pe_q   <= 1'b0;
            end else if (load) begin
               // a write beats a simultaneous clear
               v_q    <= 1'b1;
               lab_q  <= lab;
               data_q <= data;
               rp_q   <= rxpar;
               cp_q   <= calcpar;
               pe_q   <= perr;
            end else if (clr[i]) begin
               v_q <= 1'b0;
            end
         end

         assign res_valid[i]                 = v_q;
         assign res_lab[i*LOW_W +: LOW_W]    = lab_q;
         assign res_data[i*DATA_W +: DATA_W] = data_q;
         assign res_rxpar[i]                 = rp_q;
         assign res_calcpar[i]               = cp_q;
         assign res_perr[i]                  = pe_q;
      end
   endgenerate

endmodule

// File: rtl/upf_rx.sv
module upf_rx
   import upf_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 2,
   parameter int OVS         = 16,
   parameter int SAMPLE_PT   = 8,
   parameter int SYNC_STAGES = 1,
   localparam int NREG       = 1 << SEL_W,
   localparam int LOW_W      = ADDR_W - SEL_W,
   localparam int FRAME_BITS = frame_len(ADDR_W, DATA_W),
   localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sdi,
   input  logic                   sdi_invert,
   input  logic [NREG-1:0]        clr,
   output logic [NREG-1:0]        res_valid,
   output logic [NREG*LOW_W-1:0]  res_lab,
   output logic [NREG*DATA_W-1:0] res_data,
   output logic [NREG-1:0]        res_rxpar,
   output logic [NREG-1:0]        res_calcpar,
   output logic [NREG-1:0]        res_perr,
   output logic [CNT_W-1:0]       prog_cnt,
   output logic                   rx_done
);

   generate
      if (SEL_W < 1 || LOW_W < 1) begin : g_bad_addr
         $error("upf_rx: SEL_W must be at least 1 and below ADDR_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("upf_rx: DATA_W must be positive");
      end
      if (OVS < 4) begin : g_bad_ovs
         $error("upf_rx: OVS must be at least 4");
      end
      if (SAMPLE_PT < 1 || SAMPLE_PT > OVS - 2) begin : g_bad_sample
         $error("upf_rx: SAMPLE_PT must lie in 1 .. OVS-2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("upf_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                  line;
   logic                  fall;
   logic                  frame_end;
   logic [FRAME_BITS-1:0] frame;
   logic [SEL_W-1:0]      d_sel;
   logic [LOW_W-1:0]      d_lab;
   logic [DATA_W-1:0]     d_data;
   logic                  d_rxpar;
   logic                  d_calcpar;
   logic                  d_perr;

   upf_line_in #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (sdi),
      .invert (sdi_invert),
      .line   (line),
      .fall   (fall)
   );

   upf_bit_ctrl #(
      .OVS        (OVS),
      .SAMPLE_PT  (SAMPLE_PT),
      .FRAME_BITS (FRAME_BITS),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (line),
      .fall      (fall),
      .prog_cnt  (prog_cnt),
      .frame_end (frame_end),
      .frame     (frame)
   );

   upf_frame_dec #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
   ) u_dec (
      .frame   (frame),
      .sel     (d_sel),
      .lab     (d_lab),
      .data    (d_data),
      .rxpar   (d_rxpar),
      .calcpar (d_calcpar),
      .perr    (d_perr)
   );

   upf_result_bank #(
      .SEL_W  (SEL_W),
      .LOW_W  (LOW_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (frame_end),
      .sel         (d_sel),
      .lab         (d_lab),
      .data        (d_data),
      .rxpar       (d_rxpar),
      .calcpar     (d_calcpar),
      .perr        (d_perr),
      .clr         (clr),
      .res_valid   (res_valid),
      .res_lab     (res_lab),
      .res_data    (res_data),
      .res_rxpar   (res_rxpar),
      .res_calcpar (res_calcpar),
      .res_perr    (res_perr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_done <= 1'b0;
      else        rx_done <= frame_end;
   end

endmodule

// File: rtl/upf_rx_chk.sv
module upf_rx_chk #(
   parameter int NREG       = 4,
   parameter int CNT_W      = 5,
   parameter int FRAME_BITS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NREG-1:0]  clr,
   input logic [NREG-1:0]  res_valid,
   input logic [CNT_W-1:0] prog_cnt,
   input logic             rx_done
);

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_cnt <= CNT_W'(FRAME_BITS));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_cnt != $past(prog_cnt)) |->
         ((prog_cnt == $past(prog_cnt) - CNT_W'(1)) ||
          ((prog_cnt == CNT_W'(FRAME_BITS)) && ($past(prog_cnt) == '0))));

   // R8
   done_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> (prog_cnt == '0));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_slot_chk
         // R8
         valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(res_valid[i]) |-> rx_done);

         // R9
         clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> (!res_valid[i] || rx_done));

         // R10
         valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid[i] && !clr[i]) |=> res_valid[i]);
      end
   endgenerate

endmodule

bind upf_rx upf_rx_chk #(
   .NREG       (NREG),
   .CNT_W      (CNT_W),
   .FRAME_BITS (FRAME_BITS)
) u_upf_rx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .res_valid (res_valid),
   .prog_cnt  (prog_cnt),
   .rx_done   (rx_done)
);

// File: tb/tb_upf_rx.sv
module tb_upf_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdi = 1'b1;
   logic        sdi_invert = 1'b0;
   logic [3:0]  clr = '0;
   logic [3:0]  res_valid;
   logic [7:0]  res_lab;
   logic [31:0] res_data;
   logic [3:0]  res_rxpar;
   logic [3:0]  res_calcpar;
   logic [3:0]  res_perr;
   logic [4:0]  prog_cnt;
   logic        rx_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   upf_rx dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sdi         (sdi),
      .sdi_invert  (sdi_invert),
      .clr         (clr),
      .res_valid   (res_valid),
      .res_lab     (res_lab),
      .res_data    (res_data),
      .res_rxpar   (res_rxpar),
      .res_calcpar (res_calcpar),
      .res_perr    (res_perr),
      .prog_cnt    (prog_cnt),
      .rx_done     (rx_done)
   );

   // {glitch, invert, addr[3:0], data[7:0], flip_parity, stop1_low, stop2_low}
   localparam logic [16:0] VEC [8] = '{
      {1'b0, 1'b0, 4'h1, 8'hA5, 3'b000},
      {1'b0, 1'b0, 4'h6, 8'h3C, 3'b000},
      {1'b0, 1'b1, 4'hB, 8'hFF, 3'b000},
      {1'b0, 1'b0, 4'hC, 8'h00, 3'b100},
      {1'b1, 1'b0, 4'h7, 8'h5A, 3'b000},
      {1'b0, 1'b0, 4'h9, 8'h81, 3'b010},
      {1'b0, 1'b1, 4'h0, 8'h7E, 3'b001},
      {1'b0, 1'b0, 4'hE, 8'hC3, 3'b000}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic go_idle(input bit inv, input int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         sdi_invert = inv;
         sdi = 1'b1 ^ inv;
      end
   endtask

   // drives one frame; returns 1 when rx_done was seen
   task automatic send_frame(input bit inv, input logic [3:0] addr,
                             input logic [7:0] data, input bit par,
                             input bit start_hi_mid, input bit s1, input bit s2,
                             input bit glitch, input string tag,
                             output bit done_seen);
      logic [15:0] bits;
      logic        lvl;
      bits = {1'b0, addr, data, par, s1, s2};
      for (int c = 0; c < 16; c++) begin
         for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            if (t == 8 && (c == 0 || c == 1 || c == 15))
               chk(prog_cnt == 5'(16 - c), {"R3 counter ", tag}, 32'(prog_cnt),
                   32'(16 - c));
            lvl = bits[15-c];
            if (glitch && c > 0 && (t < 4 || t > 11)) lvl = ~lvl;
            if (start_hi_mid && c == 0 && t >= 4) lvl = 1'b1;
            sdi = lvl ^ inv;
         end
      end
      done_seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (rx_done && !done_seen) begin
            done_seen = 1'b1;
            break;
         end
         sdi = 1'b1 ^ inv;
      end
      sdi = 1'b1 ^ inv;
   endtask

   task automatic check_slot(input logic [3:0] addr, input logic [7:0] data,
                             input bit rxp, input bit perr, input string tag);
      int s;
      logic cp;
      s  = int'(addr[3:2]);
      cp = ^{addr, data};
      chk(res_valid[s] == 1'b1, {"R8 valid ", tag}, 32'(res_valid), 32'(1 << s));
      chk(prog_cnt == 5'd0, {"R8 counter at done ", tag}, 32'(prog_cnt), 0);
      chk({res_lab[s*2 +: 2], res_data[s*8 +: 8]} == {addr[1:0], data},
          {"R5 fields ", tag}, 32'({res_lab[s*2 +: 2], res_data[s*8 +: 8]}),
          32'({addr[1:0], data}));
      chk({res_rxpar[s], res_calcpar[s]} == {rxp, cp}, {"R6 parity ", tag},
          32'({res_rxpar[s], res_calcpar[s]}), 32'({rxp, cp}));
      chk(res_perr[s] == perr, {"R6 R7 error flag ", tag}, 32'(res_perr[s]),
          32'(perr));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      bit seen;
      logic [7:0] keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(prog_cnt == 5'd0 && res_valid == 4'd0 && !rx_done, "R1 reset state",
          32'({prog_cnt, res_valid, rx_done}), 0);

      // R1 steady high line does nothing
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (rx_done || prog_cnt != 0) seen = 1'b1;
      end
      chk(!seen && prog_cnt == 5'd0, "R1 idle line", 32'(prog_cnt), 0);

      foreach (VEC[i]) begin
         logic [16:0] v;
         string tag;
         bit rxp, perr;
         v    = VEC[i];
         tag  = v[16] ? "R4 R11 glitch row" : (v[15] ? "R2 inverted row" : "plain row");
         rxp  = (^{v[14:11], v[10:3]}) ^ v[2];
         perr = v[2] | v[1] | v[0];
         go_idle(v[15], 6);
         send_frame(v[15], v[14:11], v[10:3], rxp, 1'b0, ~v[1], ~v[0], v[16],
                    tag, seen);
         chk(seen, {"R8 done pulse ", tag}, 32'(seen), 1);
         check_slot(v[14:11], v[10:3], rxp, perr, tag);
      end

      // R10 overwrite kept the slot valid with new contents (last row hit slot 3)
      chk(res_valid == 4'hF && res_data[31:24] == 8'hC3, "R10 overwrite",
          32'({res_valid, res_data[31:24]}), 32'({4'hF, 8'hC3}));

      // R7 start bit high at its midpoint
      go_idle(1'b0, 6);
      send_frame(1'b0, 4'h4, 8'h12, ^{4'h4, 8'h12}, 1'b1, 1'b1, 1'b1, 1'b0,
                 "R7 bad start", seen);
      chk(seen, "R7 done after bad start", 32'(seen), 1);
      check_slot(4'h4, 8'h12, ^{4'h4, 8'h12}, 1'b1, "R7 bad start");

      // R9 clear one slot
      keep = res_data[23:16];
      @(negedge clk);
      clr = 4'b0100;
      @(negedge clk);
      clr = 4'b0000;
      chk(res_valid == 4'b1011, "R9 clear slot 2", 32'(res_valid), 32'hB);
      chk(res_data[23:16] == keep, "R9 data kept", 32'(res_data[23:16]),
          32'(keep));

      // R1 idle after everything
      go_idle(1'b0, 20);
      chk(prog_cnt == 5'd0 && !rx_done, "R1 idle again", 32'(prog_cnt), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule